// File: doc/BRIEF.md
# Parallel Sub-Chain Scan Pattern Source

This block fills one long scan chain that has been cut into several equal sub-chains, and loads every sub-chain in the same clock cycles. A single 16-bit LFSR drives the whole chain. Any bit that the register would shift out in a later cycle is a fixed XOR of the bits it holds now. A small XOR network therefore computes, for each sub-chain, the bit that a one-wire serial fill would have delivered to that sub-chain's entry. Every sub-chain then ends with the same contents it would hold after a serial fill, but the fill takes only the sub-chain length in cycles. Seeds chosen for deterministic patterns keep their meaning, and both shift time and shift energy drop.

The seed is written with a one-cycle load pulse. A one-cycle start pulse then runs one pattern fill. When the fill ends, the generator state has moved on by the full chain length. A following start therefore continues the same serial sequence, exactly as a serial fill of the next pattern would.

Top module: `sbist_multichain_gen`

## Requirements
- R1: During reset and after it, `shift_active`, `shift_done` and `scan_bits` are 0. The generator state resets to 16'hACE1, so a start with no prior seed load produces the stream of that seed.
- R2: A `seed_load` pulse while no fill is running writes `seed` into the generator. A `start` in the same cycle begins the fill from the new seed.
- R3: A `start` pulse while no fill is running raises `shift_active` at the next clock edge. `shift_active` then stays high for exactly CHAIN_LEN/SUBCHAINS = 16 cycles.
- R4: `shift_done` is high for exactly one cycle: the cycle right after the last shift cycle.
- R5: The serial stream is defined as follows. Bit n is bit 0 of the state after n steps. One step is `s <= {^(s & 16'h002D), s[15:1]}`. In shift cycle t (t = 0..15), `scan_bits[j]` equals serial bit 16*j + t. Concatenating the four sub-chains therefore yields serial bits 0..63.
- R6: A fill starts where the previous fill ended, 64 steps later. The second fill from one seed therefore delivers serial bits 64..127.
- R7: A `start` while a fill is running is ignored. The fill keeps its length and its data.
- R8: A `seed_load` while a fill is running is ignored. Neither the current fill nor the next one is altered.
- R9: `scan_bits` is 0 in every cycle where `shift_active` is low.
- R10: An all-zero seed yields all-zero scan bits for the whole fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| seed_load | input | 1 | One-cycle pulse that writes `seed` into the generator |
| seed | input | 16 | Seed value |
| start | input | 1 | One-cycle pulse that begins a chain fill |
| scan_bits | output | 4 | One scan-in bit per sub-chain; bit j feeds sub-chain j |
| shift_active | output | 1 | High in each cycle where the sub-chains must shift |
| shift_done | output | 1 | One-cycle pulse after the last shift cycle |

## Verification
A wrong XOR mask for one sub-chain corrupts only that lane. It shows in `scan_bits[j]` within the first fill, often in the first shift cycle. A wrong end-of-fill jump leaves the first fill correct and shows in the first cycle of the next fill. The bench therefore always runs two fills per seed. A counter or state error shows at once as an active window that is not 16 cycles long, or as a missing or stretched done pulse. A missed busy guard shows as data that departs from the serial model right after the stray `start` or `seed_load` pulse.

// File: rtl/sbist_pkg.sv
package sbist_pkg;

  localparam int unsigned LFSR_W = 16;
  // Feedback taps: the new top bit is the XOR of the state bits set here.
  localparam logic [LFSR_W-1:0] TAP_MASK = 16'h002D;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_DONE  = 2'd2
  } fill_state_e;

  // Returns which present-state bits are XORed to give state bit bit_idx
  // after 'steps' shifts (one row of the transition matrix power).
  function automatic logic [LFSR_W-1:0] dep_mask(int unsigned steps, int unsigned bit_idx);
    logic [LFSR_W-1:0][LFSR_W-1:0] m;
    logic [LFSR_W-1:0]             fb;
    for (int i = 0; i < int'(LFSR_W); i++) begin
      m[i]    = '0;
      m[i][i] = 1'b1;
    end
    for (int unsigned s = 0; s < steps; s++) begin
      fb = '0;
      for (int i = 0; i < int'(LFSR_W); i++) begin
        if (TAP_MASK[i]) fb = fb ^ m[i];
      end
      for (int i = 0; i < int'(LFSR_W) - 1; i++) begin
        m[i] = m[i+1];
      end
      m[LFSR_W-1] = fb;
    end
    return m[bit_idx];
  endfunction

endpackage

// File: rtl/sbist_rst_sync.sv
module sbist_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/sbist_lfsr.sv
module sbist_lfsr
  import sbist_pkg::*;
#(
  parameter logic [LFSR_W-1:0] RESET_SEED = 16'hACE1,
  parameter int unsigned       JUMP_STEPS = 49
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [LFSR_W-1:0] load_val,
  input  logic              step_en,
  input  logic              jump_en,
  output logic [LFSR_W-1:0] state_q
);
  logic [LFSR_W-1:0] step_next;
  logic [LFSR_W-1:0] jump_next;
  logic [LFSR_W-1:0] state_d;
  logic              state_en;

  assign step_next = {^(state_q & TAP_MASK), state_q[LFSR_W-1:1]};

  // Multi-step advance used on the last shift cycle.
  for (genvar b = 0; b < int'(LFSR_W); b++) begin : g_jump
    localparam logic [LFSR_W-1:0] ROW = dep_mask(JUMP_STEPS, b);
    assign jump_next[b] = ^(state_q & ROW);
  end

  always_comb begin
    state_en = load_en | step_en | jump_en;
    if (load_en)      state_d = load_val;
    else if (jump_en) state_d = jump_next;
    else              state_d = step_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= RESET_SEED;
    else if (state_en) state_q <= state_d;
  end

  // R2
  seed_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> state_q == $past(load_val));

  // R10
  nonzero_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != '0 && !load_en) |=> state_q != '0);

  // R10
  zero_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == '0 && !load_en) |=> state_q == '0);
endmodule

// File: rtl/sbist_phase_net.sv
module sbist_phase_net
  import sbist_pkg::*;
#(
  parameter int unsigned SUBCHAINS = 4,
  parameter int unsigned SEG_LEN   = 16
) (
  input  logic [LFSR_W-1:0]    state,
  input  logic                 enable,
  output logic [SUBCHAINS-1:0] bits
);
  // Lane j carries the serial output j*SEG_LEN cycles ahead.
  for (genvar j = 0; j < int'(SUBCHAINS); j++) begin : g_lane
    localparam logic [LFSR_W-1:0] MASK = dep_mask(j * SEG_LEN, 0);
    assign bits[j] = enable & (^(state & MASK));
  end
endmodule

// File: rtl/sbist_fill_ctrl.sv
module sbist_fill_ctrl
  import sbist_pkg::*;
#(
  parameter int unsigned SEG_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic shift_active,
  output logic last_shift,
  output logic load_ok,
  output logic done
);
  localparam int unsigned     CNT_W = (SEG_LEN > 1) ? $clog2(SEG_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SEG_LEN - 1);

  fill_state_e      st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    case (st_q)
      ST_SHIFT: begin
        cnt_en = 1'b1;
        if (cnt_q == LAST) begin
          st_d  = ST_DONE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        if (start) begin
          st_d   = ST_SHIFT;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end else begin
          st_d = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign shift_active = (st_q == ST_SHIFT);
  assign last_shift   = shift_active && (cnt_q == LAST);
  assign load_ok      = !shift_active;
  assign done         = (st_q == ST_DONE);

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_shift |=> (done && !shift_active));

  // R3
  window_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_active && !last_shift) |=> shift_active);

  // R7
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shift_active) |-> $past(start));
endmodule

// File: rtl/sbist_multichain_gen.sv
module sbist_multichain_gen
  import sbist_pkg::*;
#(
  parameter int unsigned       CHAIN_LEN  = 64,
  parameter int unsigned       SUBCHAINS  = 4,
  parameter logic [LFSR_W-1:0] RESET_SEED = 16'hACE1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 seed_load,
  input  logic [LFSR_W-1:0]    seed,
  input  logic                 start,
  output logic [SUBCHAINS-1:0] scan_bits,
  output logic                 shift_active,
  output logic                 shift_done
);
  localparam int unsigned SEG_LEN    = CHAIN_LEN / SUBCHAINS;
  localparam int unsigned JUMP_STEPS = CHAIN_LEN - SEG_LEN + 1;

  logic              rst_i_n;
  logic              last_shift;
  logic              load_ok;
  logic              active_i;
  logic [LFSR_W-1:0] gen_state;

  sbist_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  sbist_fill_ctrl #(.SEG_LEN(SEG_LEN)) i_ctrl (
    .clk          (clk),
    .rst_n        (rst_i_n),
    .start        (start),
    .shift_active (active_i),
    .last_shift   (last_shift),
    .load_ok      (load_ok),
    .done         (shift_done)
  );

  sbist_lfsr #(.RESET_SEED(RESET_SEED), .JUMP_STEPS(JUMP_STEPS)) i_lfsr (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load_en  (seed_load & load_ok),
    .load_val (seed),
    .step_en  (active_i & ~last_shift),
    .jump_en  (last_shift),
    .state_q  (gen_state)
  );

  sbist_phase_net #(.SUBCHAINS(SUBCHAINS), .SEG_LEN(SEG_LEN)) i_net (
    .state  (gen_state),
    .enable (active_i),
    .bits   (scan_bits)
  );

  assign shift_active = active_i;

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !shift_active |-> scan_bits == '0);

  // R5
  lane0_now_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    shift_active |-> scan_bits[0] == gen_state[0]);

  // R8
  busy_seed_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (shift_active && !last_shift) |=> gen_state == {^($past(gen_state) & TAP_MASK), $past(gen_state[LFSR_W-1:1])});
endmodule

// File: tb/test_sbist_multichain_gen.sv
module test_sbist_multichain_gen;
  logic        clk;
  logic        rst_n;
  logic        seed_load;
  logic [15:0] seed;
  logic        start;
  logic [3:0]  scan_bits;
  logic        shift_active;
  logic        shift_done;

  int total_cnt = 0;
  int fail_cnt  = 0;
  logic [15:0] ms;

  sbist_multichain_gen i_sbist_multichain_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .seed_load    (seed_load),
    .seed         (seed),
    .start        (start),
    .scan_bits    (scan_bits),
    .shift_active (shift_active),
    .shift_done   (shift_done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [15:0] nstep(logic [15:0] s);
    return {s[0] ^ s[2] ^ s[3] ^ s[5], s[15:1]};
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total_cnt++;
    if (!ok) begin
      fail_cnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // poke: 0 none, 1 start mid-fill, 2 seed_load mid-fill
  task automatic run_fill(input logic use_seed, input logic [15:0] sd,
                          input int poke, input string tag);
    logic [63:0] ser;
    logic [3:0]  exp_b;
    @(negedge clk);
    if (use_seed) begin
      seed_load = 1'b1;
      seed      = sd;
      ms        = sd;
    end
    start = 1'b1;
    for (int n = 0; n < 64; n++) begin
      ser[n] = ms[0];
      ms     = nstep(ms);
    end
    for (int t = 0; t < 16; t++) begin
      @(negedge clk);
      seed_load = 1'b0;
      start     = 1'b0;
      if (t == 5 && poke == 1) start = 1'b1;
      if (t == 5 && poke == 2) begin
        seed_load = 1'b1;
        seed      = 16'h1234;
      end
      for (int j = 0; j < 4; j++) exp_b[j] = ser[16*j + t];
      check(shift_active == 1'b1, "R3", "active in window", 32'(shift_active), 1);
      check(shift_done == 1'b0, "R4", "done inside window", 32'(shift_done), 0);
      check(scan_bits == exp_b, tag, "lane bits", 32'(scan_bits), 32'(exp_b));
    end
    @(negedge clk);
    seed_load = 1'b0;
    start     = 1'b0;
    check(shift_active == 1'b0, "R3", "active after 16", 32'(shift_active), 0);
    check(shift_done == 1'b1, "R4", "done pulse", 32'(shift_done), 1);
    check(scan_bits == 4'h0, "R9", "bits when idle", 32'(scan_bits), 0);
    @(negedge clk);
    check(shift_done == 1'b0, "R4", "done width", 32'(shift_done), 0);
    check(scan_bits == 4'h0, "R9", "bits idle after done", 32'(scan_bits), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fail_cnt++;
    total_cnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total_cnt - fail_cnt, total_cnt);
    $finish;
  end

  initial begin
    logic [15:0] seeds [6];
    seeds[0] = 16'h0001; seeds[1] = 16'hFFFF; seeds[2] = 16'h8000;
    seeds[3] = 16'h5A5A; seeds[4] = 16'hC3A7; seeds[5] = 16'h0000;
    rst_n = 1'b0; seed_load = 1'b0; seed = 16'h0; start = 1'b0;
    repeat (4) @(negedge clk);
    check(shift_active == 1'b0 && shift_done == 1'b0 && scan_bits == 4'h0,
          "R1", "outputs in reset", 32'({shift_active, shift_done, scan_bits}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(shift_active == 1'b0 && shift_done == 1'b0 && scan_bits == 4'h0,
          "R1", "outputs after reset", 32'({shift_active, shift_done, scan_bits}), 0);
    ms = 16'hACE1;
    run_fill(1'b0, 16'h0, 0, "R1");
    run_fill(1'b0, 16'h0, 0, "R6");
    for (int k = 0; k < 6; k++) begin
      run_fill(1'b1, seeds[k], 0, (seeds[k] == 16'h0) ? "R10" : "R2");
      run_fill(1'b0, 16'h0, 0, (seeds[k] == 16'h0) ? "R10" : "R6");
    end
    run_fill(1'b1, 16'hBEEF, 1, "R7");
    run_fill(1'b0, 16'h0, 0, "R7");
    run_fill(1'b1, 16'h2468, 2, "R8");
    run_fill(1'b0, 16'h0, 0, "R8");
    run_fill(1'b0, 16'h0, 0, "R5");
    $display("%0d/%0d checks passed", total_cnt - fail_cnt, total_cnt);
    $finish;
  end
endmodule